// File: doc/BRIEF.md
# Transmit Lane Phase Aligner

This controller brings every transmit lane of a multi-lane serial transmitter to the same repeatable phase after reset. The only phase information it gets is a one-bit half-full status from the lane's transmit elastic buffer. It moves the lane's transmit phase interpolator one code at a time, which shifts the buffer's read clock against its write clock. After each move it reads that status bit as a phase detector.

A start pulse with a lane select begins a run for that lane. The interpolator code counts from 0, relative to wherever the hardware happens to sit. After each step, and once before the first step, the block raises `settling` for a programmable number of cycles. It then samples the status on `VOTES` consecutive cycles and takes the majority. The first phase of the search steps until both status values have been seen, which brackets the transition. The second phase steps on until a 0 decision is followed by a 1 decision. At that code the write-to-read pointer distance is half the buffer depth.

The locked code is held, `done` rises and the status bit is ignored until the next start. A sweep over the whole code range with no transition raises `err` and stops stepping. Lanes are aligned one after another: each lane keeps its own locked code and its own done bit. Running the alignment again after every reset removes slow drift that builds up between resets.

Top module: `txpa_align`

## Requirements
- R1: During and right after reset, `done`, `err`, `pi_step`, `settling`, `pi_code` and every `lane_done` bit are 0.
- R2: In the cycle after a `start` pulse, `pi_code` is 0, `done` and `err` are 0, `pi_lane` equals the sampled `lane_sel`, and `lane_done` of that lane is 0. Other lanes' bits keep their values.
- R3: `pi_step` is a one-cycle pulse. In the cycle it is high, `pi_code` has just advanced by exactly one. It wraps from CODES-1 to 0, where CODES = 2^CODE_W. `pi_code` never changes in any other way except on a start.
- R4: Before each decision, `settling` is high for exactly `settle_len`+1 consecutive cycles. The status input is ignored during those cycles.
- R5: Each decision is the majority of `VOTES` status samples taken on consecutive cycles right after `settling` falls. A single wrong sample in the window does not change the decision.
- R6: The run locks at the first code whose decision is 1 while the previous decision in the same run was 0. For a status that is 1 exactly when (code + k) mod CODES ≥ CODES/2, the locked code is (CODES/2 − k) mod CODES. This holds for every k, whatever status the run starts on.
- R7: If the first CODES decisions of a run are all equal, `err` rises with `pi_code` = CODES−1 after CODES−1 steps. Stepping then stops, and the code is held until the next start.
- R8: After a lock, `done` stays high, `pi_code` is held and `pi_step` stays low, whatever the status input does, until the next start.
- R9: On lock, the code is stored for `pi_lane` and that lane's `lane_done` bit is set. `lock_code` shows the stored code of the lane picked by `lane_sel`. Other lanes' stored codes are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) alignment of the lane on `lane_sel` |
| lane_sel | input | LANE_W | Lane to align on start; also the readback select for `lock_code` |
| settle_len | input | SETTLE_W | Settle wait after each step, in cycles minus one |
| buf_half | input | 1 | Half-full status of the selected lane's transmit buffer |
| pi_step | output | 1 | One-cycle command to advance the interpolator by one code |
| pi_lane | output | LANE_W | Lane currently under alignment |
| pi_code | output | CODE_W | Current interpolator code of the run |
| settling | output | 1 | High while waiting for the interpolator to settle |
| done | output | 1 | Run locked |
| err | output | 1 | Run found no transition |
| lane_done | output | LANES | Per-lane locked flags |
| lock_code | output | CODE_W | Stored locked code of lane `lane_sel` |

## Verification
A wrong search state, such as a lost "previous decision" or a phase flag that never sets, shows up at the ports as a wrong `lock_code` and `pi_code` when `done` rises. It also shows as a wrong number of `pi_step` pulses, within one sweep of at most 2·CODES steps. Settle or vote counter faults show in the very first settle window as a `settling` run of the wrong length, or as a changed lock code when single samples are corrupted. A faulty hold shows up within a cycle or two of toggling the status after lock.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
  typedef enum logic [2:0] {
    C_IDLE, C_KICK, C_WAIT, C_STEP, C_LOCK, C_FAIL
  } ctrl_st_t;

  typedef enum logic [1:0] {
    V_IDLE, V_SETTLE, V_SAMPLE
  } vote_st_t;
endpackage

// File: rtl/txpa_vote.sv
module txpa_vote #(
  parameter int SETTLE_W = 8,
  parameter int VOTES    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic                kick,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                flag,
  output logic                settling,
  output logic                res_valid,
  output logic                res_bit
);
  import txpa_pkg::*;

  localparam int VW = $clog2(VOTES + 1);

  vote_st_t            st;
  logic [SETTLE_W-1:0] scnt;
  logic [VW-1:0]       vcnt;
  logic [VW-1:0]       ones;
  logic [VW-1:0]       total;

  assign total    = ones + VW'(flag);
  assign settling = (st == V_SETTLE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st        <= V_IDLE;
      scnt      <= '0;
      vcnt      <= '0;
      ones      <= '0;
      res_valid <= 1'b0;
      res_bit   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        V_IDLE: if (kick) begin
          st   <= V_SETTLE;
          scnt <= settle_len;
        end
        V_SETTLE: begin
          if (scnt == '0) begin
            st   <= V_SAMPLE;
            vcnt <= '0;
            ones <= '0;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        V_SAMPLE: begin
          if (vcnt == VW'(VOTES - 1)) begin
            st        <= V_IDLE;
            res_valid <= 1'b1;
            res_bit   <= (total > VW'(VOTES / 2));
          end else begin
            ones <= total;
            vcnt <= vcnt + 1'b1;
          end
        end
        default: st <= V_IDLE;
      endcase
    end
  end

  assert_settle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (settling && scnt != '0 && !abort) |=> settling);
  assert_result_after_window_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !settling && $past(st == V_SAMPLE));
endmodule

// File: rtl/txpa_lane_store.sv
module txpa_lane_store #(
  parameter int LANES  = 8,
  parameter int CODE_W = 7,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [LANE_W-1:0] clr_lane,
  input  logic              wr,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [LANES-1:0]  lane_done,
  output logic [CODE_W-1:0] rd_code
);
  logic [CODE_W-1:0] code_r [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        code_r[g]    <= '0;
        lane_done[g] <= 1'b0;
      end else if (clr && clr_lane == LANE_W'(g)) begin
        lane_done[g] <= 1'b0;
      end else if (wr && wr_lane == LANE_W'(g)) begin
        code_r[g]    <= wr_code;
        lane_done[g] <= 1'b1;
      end
    end
  end

  assign rd_code = code_r[rd_lane];

  assert_done_on_lock_R9: assert property (@(posedge clk) disable iff (rst)
    wr |=> lane_done[$past(wr_lane)]);
endmodule

// File: rtl/txpa_ctrl.sv
module txpa_ctrl #(
  parameter int CODE_W = 7,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic              res_valid,
  input  logic              res_bit,
  output logic              kick,
  output logic              pi_step,
  output logic [CODE_W-1:0] pi_code,
  output logic [LANE_W-1:0] pi_lane,
  output logic              done,
  output logic              err,
  output logic              lock_evt
);
  import txpa_pkg::*;

  localparam logic [CODE_W-1:0] STEP_MAX = '1;

  ctrl_st_t          st;
  logic [CODE_W-1:0] steps;
  logic              prev, have_prev, phase2;
  logic              trans;

  assign trans    = have_prev && (prev != res_bit);
  assign lock_evt = (st == C_WAIT) && res_valid && !start &&
                    have_prev && !prev && res_bit;
  assign kick     = (st == C_KICK) || (st == C_STEP);
  assign pi_step  = (st == C_STEP);
  assign done     = (st == C_LOCK);
  assign err      = (st == C_FAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      pi_code   <= '0;
      pi_lane   <= '0;
      steps     <= '0;
      prev      <= 1'b0;
      have_prev <= 1'b0;
      phase2    <= 1'b0;
    end else if (start) begin
      st        <= C_KICK;
      pi_code   <= '0;
      pi_lane   <= lane_sel;
      steps     <= '0;
      prev      <= 1'b0;
      have_prev <= 1'b0;
      phase2    <= 1'b0;
    end else begin
      case (st)
        C_KICK, C_STEP: st <= C_WAIT;
        C_WAIT: if (res_valid) begin
          if (lock_evt) begin
            st <= C_LOCK;
          end else begin
            prev      <= res_bit;
            have_prev <= 1'b1;
            if (!phase2 && trans) begin
              phase2  <= 1'b1;
              steps   <= CODE_W'(1);
              pi_code <= pi_code + 1'b1;
              st      <= C_STEP;
            end else if (steps == STEP_MAX) begin
              st <= C_FAIL;
            end else begin
              steps   <= steps + 1'b1;
              pi_code <= pi_code + 1'b1;
              st      <= C_STEP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    pi_step |-> pi_code == $past(pi_code) + 1'b1);
  assert_step_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    pi_step |=> !pi_step);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (pi_code == '0 && !done && !err));
  assert_hold_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pi_code)));
  assert_hold_failed_R7: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> (err && $stable(pi_code)));
endmodule

// File: rtl/txpa_align.sv
module txpa_align #(
  parameter int LANES    = 8,
  parameter int CODE_W   = 7,
  parameter int SETTLE_W = 8,
  parameter int VOTES    = 3,
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LANE_W-1:0]   lane_sel,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                buf_half,
  output logic                pi_step,
  output logic [LANE_W-1:0]   pi_lane,
  output logic [CODE_W-1:0]   pi_code,
  output logic                settling,
  output logic                done,
  output logic                err,
  output logic [LANES-1:0]    lane_done,
  output logic [CODE_W-1:0]   lock_code
);
  logic kick, res_valid, res_bit, lock_evt;

  txpa_vote #(.SETTLE_W(SETTLE_W), .VOTES(VOTES)) u_vote (
    .clk(clk), .rst(rst), .abort(start), .kick(kick),
    .settle_len(settle_len), .flag(buf_half),
    .settling(settling), .res_valid(res_valid), .res_bit(res_bit)
  );

  txpa_ctrl #(.CODE_W(CODE_W), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .lane_sel(lane_sel),
    .res_valid(res_valid), .res_bit(res_bit), .kick(kick),
    .pi_step(pi_step), .pi_code(pi_code), .pi_lane(pi_lane),
    .done(done), .err(err), .lock_evt(lock_evt)
  );

  txpa_lane_store #(.LANES(LANES), .CODE_W(CODE_W), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst(rst), .clr(start), .clr_lane(lane_sel),
    .wr(lock_evt), .wr_lane(pi_lane), .wr_code(pi_code),
    .rd_lane(lane_sel), .lane_done(lane_done), .rd_code(lock_code)
  );

  assert_no_step_while_settling_R4: assert property (@(posedge clk) disable iff (rst)
    pi_step |-> !settling);
  assert_done_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err, settling}));
endmodule

// File: tb/txpa_align_bench.sv
module txpa_align_bench;
  localparam int LANES = 8, CODE_W = 5, SETTLE_W = 4, VOTES = 3;
  localparam int CODES = 1 << CODE_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, buf_half;
  logic [2:0] lane_sel;
  logic [SETTLE_W-1:0] settle_len;
  logic pi_step, settling, done, err;
  logic [2:0] pi_lane;
  logic [CODE_W-1:0] pi_code, lock_code;
  logic [LANES-1:0] lane_done;

  txpa_align #(.LANES(LANES), .CODE_W(CODE_W), .SETTLE_W(SETTLE_W), .VOTES(VOTES)) u_txpa_align (
    .clk(clk), .rst(rst), .start(start), .lane_sel(lane_sel), .settle_len(settle_len),
    .buf_half(buf_half), .pi_step(pi_step), .pi_lane(pi_lane), .pi_code(pi_code),
    .settling(settling), .done(done), .err(err), .lane_done(lane_done), .lock_code(lock_code)
  );

  int off [LANES];
  int mode = 0;          // 0 model, 1 stuck 0, 2 stuck 1, 3 toggling
  bit noise_settle = 0, noise_vote = 0;
  int cyc = 0;
  int errs = 0, checks = 0;
  int nsteps = 0, bad_inc = 0, bad_set = 0, srun = 0;
  logic [CODE_W-1:0] last = '0;

  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic model(logic [CODE_W-1:0] c, logic [2:0] ln, int m,
                                 logic st, int cy, bit ns, bit nv);
    logic b;
    case (m)
      1: b = 1'b0;
      2: b = 1'b1;
      3: b = cy[0];
      default: b = ((int'(c) + off[ln]) % CODES) >= CODES / 2;
    endcase
    if ((ns && st) || (nv && !st && (cy % 3 == 0))) b = ~b;
    return b;
  endfunction

  assign buf_half = model(pi_code, pi_lane, mode, settling, cyc, noise_settle, noise_vote);

  always @(negedge clk) begin
    if (pi_step) begin
      nsteps++;
      if (pi_code != CODE_W'(int'(last) + 1)) bad_inc++;
    end
    last = pi_code;
    if (settling) srun++;
    else if (srun > 0) begin
      if (srun != int'(settle_len) + 1) bad_set++;
      srun = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lock(int k);
    return (((CODES / 2 - k) % CODES) + CODES) % CODES;
  endfunction

  task automatic wait_end();
    int n = 0;
    while (!(done || err)) begin
      @(negedge clk);
      n++;
      if (n > 6000) begin
        chk(0, "watchdog", n, 0);
        return;
      end
    end
  endtask

  task automatic run(int lane, int k, int sl);
    off[lane] = k;
    settle_len = SETTLE_W'(sl);
    @(negedge clk);
    lane_sel = 3'(lane);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nsteps = 0; bad_inc = 0; bad_set = 0; srun = 0;
    chk(pi_code == 0 && !done && !err && !lane_done[lane] && int'(pi_lane) == lane,
        "R2 start clears", int'(pi_code), 0);
    wait_end();
  endtask

  initial begin
    #(20 * 190000);
    chk(0, "global watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) off[i] = 0;
    rst = 1'b1; start = 1'b0; lane_sel = '0; settle_len = '0;
    repeat (3) @(negedge clk);
    chk(!done && !err && !pi_step && !settling && pi_code == 0 && lane_done == 0,
        "R1 in reset", int'(lane_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !err && !pi_step && !settling && pi_code == 0 && lane_done == 0,
        "R1 after reset", int'(pi_code), 0);

    // R6 exhaustive over all phase offsets, R3 and R4 observed on every run
    for (int k = 0; k < CODES; k++) begin
      int e, es;
      run(k % LANES, k, k % 4);
      e = exp_lock(k);
      es = (e == 0) ? CODES : e;
      chk(done && !err, "R6 locks", int'(done), 1);
      chk(int'(pi_code) == e, "R6 lock code", int'(pi_code), e);
      chk(int'(lock_code) == e, "R9 stored code", int'(lock_code), e);
      chk(nsteps == es, "R6 step count", nsteps, es);
      chk(bad_inc == 0, "R3 single-code steps", bad_inc, 0);
      chk(bad_set == 0, "R4 settle length", bad_set, 0);
    end

    // R4: status ignored while settling
    noise_settle = 1;
    for (int k = 3; k < CODES; k += 5) begin
      run(1, k, 4);
      chk(int'(pi_code) == exp_lock(k), "R4 noise in settle ignored", int'(pi_code), exp_lock(k));
    end
    noise_settle = 0;

    // R5: single wrong sample per vote window
    noise_vote = 1;
    for (int k = 2; k < CODES; k += 5) begin
      run(2, k, 1);
      chk(done && int'(pi_code) == exp_lock(k), "R5 majority vote", int'(pi_code), exp_lock(k));
    end
    noise_vote = 0;

    // R8: hold after lock
    begin
      logic [CODE_W-1:0] held;
      int pulses = 0;
      held = pi_code;
      mode = 3;
      repeat (20) begin
        @(negedge clk);
        if (pi_step) pulses++;
      end
      chk(done && pi_code == held, "R8 code held", int'(pi_code), int'(held));
      chk(pulses == 0, "R8 no steps after lock", pulses, 0);
      mode = 0;
    end

    // R7: no transition in a full sweep
    for (int m = 1; m <= 2; m++) begin
      int pulses = 0;
      mode = m;
      run(4, 0, 1);
      chk(err && !done, "R7 error raised", int'(err), 1);
      chk(int'(pi_code) == CODES - 1, "R7 final code", int'(pi_code), CODES - 1);
      chk(nsteps == CODES - 1, "R7 step count", nsteps, CODES - 1);
      chk(!lane_done[4], "R7 lane not done", int'(lane_done[4]), 0);
      repeat (10) begin
        @(negedge clk);
        if (pi_step) pulses++;
      end
      chk(err && pulses == 0 && int'(pi_code) == CODES - 1, "R7 held", pulses, 0);
    end
    mode = 0;

    // R9: lanes one after another, each keeps its own result
    for (int l = 0; l < LANES; l++) run(l, 5 * l + 1, 2);
    chk(lane_done == '1, "R9 all lanes done", int'(lane_done), (1 << LANES) - 1);
    for (int l = 0; l < LANES; l++) begin
      @(negedge clk);
      lane_sel = 3'(l);
      #1;
      chk(int'(lock_code) == exp_lock(5 * l + 1), "R9 per-lane code", int'(lock_code), exp_lock(5 * l + 1));
    end
    run(2, 30, 0);
    chk(done && int'(lock_code) == exp_lock(30), "R9 relocked lane", int'(lock_code), exp_lock(30));
    for (int l = 0; l < LANES; l++) begin
      if (l != 2) begin
        @(negedge clk);
        lane_sel = 3'(l);
        #1;
        chk(int'(lock_code) == exp_lock(5 * l + 1), "R9 other lanes untouched", int'(lock_code), exp_lock(5 * l + 1));
      end
    end
    chk(lane_done == '1, "R9 done bits after relock", int'(lane_done), (1 << LANES) - 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule